// File: doc/BRIEF.md
# Bit-Sliced Pipelined Adder

This block adds two unsigned operands plus a carry-in. The carry path is cut by a register after every bit position. Each bit position is a one-bit full-adder stage. A stage combines its operand bits with the carry that the stage below it registered one cycle earlier. Because of this, a long carry chain never has to settle inside one clock period.

The operand bits are staggered on the way in. Bit k waits k cycles, so it reaches its stage in the same cycle as the carry it needs. Finished sum bits are staggered the other way on the way out. The low bits wait longest, so the whole sum word and the carry-out leave together.

A valid flag travels with each operation. A new operand pair can enter on every clock. The default width is four bits, which gives a fixed four-cycle latency.

Top module: `bpa_adder`

## Requirements
- R1: When `out_valid_o` is high, `{cout_o, sum_o}` equals the unsigned value `a_i + b_i + cin_i` of the operation accepted WIDTH cycles earlier, where bit WIDTH is the carry-out.
- R2: `out_valid_o` is high exactly WIDTH clock cycles after `in_valid_i` was sampled high, with no reset in between, and is low otherwise.
- R3: Operations presented on consecutive cycles each produce their own result on consecutive cycles, one per clock.
- R4: A carry propagates correctly through every bit position. Examples: 4'hF + 4'h0 + 1 gives sum 0 with carry-out 1, and 4'hF + 4'hF + 1 gives sum 4'hF with carry-out 1.
- R5: While reset is held, and in the first cycle after it is applied, `out_valid_o`, `sum_o` and `cout_o` are all 0.
- R6: Operations still in flight when reset is applied are discarded. No valid result appears for them after reset is released.
- R7: A cycle with `in_valid_i` low produces a cycle with `out_valid_o` low in the matching output slot. The results of the valid neighbours on either side are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands are valid this cycle |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| out_valid_o | output | 1 | Result is valid this cycle |
| sum_o | output | WIDTH | Sum word |
| cout_o | output | 1 | Carry-out of the top bit |

## Verification
Every operand pair is streamed back to back, each with both carry-in values, so each bit stage sees generate, propagate and kill patterns under every possible incoming carry. The same sweep is repeated with idle slots inserted. This separates correct valid tracking from a design that merely holds the last result. Chosen all-ones cases force a carry to ripple through every stage, and these show a carry register that is missing or misaligned. A reset applied while operations are in flight tells whether any pipeline or skew register escapes clearing.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    localparam int unsigned DEFAULT_WIDTH = 4;

    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x | y));
        return r;
    endfunction

endpackage

// File: rtl/bpa_delay.sv
module bpa_delay #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] sh;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh <= '0;
        end else begin
            sh[0] <= d_i;
            for (int i = 1; i < int'(DEPTH); i++) begin
                sh[i] <= sh[i-1];
            end
        end
    end

    assign q_o = sh[DEPTH-1];
endmodule

// File: rtl/bpa_stage.sv
module bpa_stage
    import bpa_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic sum_o,
    output logic carry_o
);
    fa_out_t q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else begin
            q <= full_add(a_i, b_i, c_i);
        end
    end

    assign sum_o   = q.s;
    assign carry_o = q.c;

    // R4: both operand bits set must generate a carry into the next stage
    a_r4_generate: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(a_i && b_i) && !$past(rst_i)) |-> carry_o);

    // R4: both operand bits clear must kill any carry
    a_r4_kill: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!a_i && !b_i) && !$past(rst_i)) |-> !carry_o);
endmodule

// File: rtl/bpa_adder.sv
module bpa_adder
    import bpa_pkg::*;
#(
    parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic             out_valid_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int unsigned LAT = WIDTH;

    logic [WIDTH-1:0] a_sk, b_sk;
    logic [WIDTH-1:0] s_raw;
    logic [WIDTH:0]   carry;

    assign carry[0] = cin_i;

    for (genvar k = 0; k < int'(WIDTH); k++) begin : g_bit
        if (k == 0) begin : g_noskew
            assign a_sk[k] = a_i[k];
            assign b_sk[k] = b_i[k];
        end else begin : g_skew
            bpa_delay #(.DEPTH(k)) u_a_skew (
                .clk_i(clk_i), .rst_i(rst_i), .d_i(a_i[k]), .q_o(a_sk[k]));
            bpa_delay #(.DEPTH(k)) u_b_skew (
                .clk_i(clk_i), .rst_i(rst_i), .d_i(b_i[k]), .q_o(b_sk[k]));
        end

        bpa_stage u_stage (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .a_i    (a_sk[k]),
            .b_i    (b_sk[k]),
            .c_i    (carry[k]),
            .sum_o  (s_raw[k]),
            .carry_o(carry[k+1])
        );

        if (k == int'(WIDTH) - 1) begin : g_nodeskew
            assign sum_o[k] = s_raw[k];
        end else begin : g_deskew
            bpa_delay #(.DEPTH(WIDTH - 1 - k)) u_s_deskew (
                .clk_i(clk_i), .rst_i(rst_i), .d_i(s_raw[k]), .q_o(sum_o[k]));
        end
    end

    bpa_delay #(.DEPTH(LAT)) u_valid (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(in_valid_i), .q_o(out_valid_o));

    assign cout_o = carry[WIDTH];

    // R5: the cycle after reset every output is cleared
    a_r5_reset_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!out_valid_o && sum_o == '0 && !cout_o));

    if (WIDTH <= 8) begin : g_chk
        // R2: a valid result only follows a valid input LAT cycles back
        a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (rst_i)
            out_valid_o |-> $past(in_valid_i, LAT));

        // R1: the result matches the arithmetic sum of the aligned operands
        a_r1_sum: assert property (@(posedge clk_i) disable iff (rst_i)
            out_valid_o |-> ({cout_o, sum_o} ==
                ({1'b0, $past(a_i, LAT)} + {1'b0, $past(b_i, LAT)}
                 + {{WIDTH{1'b0}}, $past(cin_i, LAT)})));
    end
endmodule

// File: tb/bpa_adder_tb.sv
module bpa_adder_tb;
    localparam int W = 4;
    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vin = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic         vout;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic         hv [L];
    logic [W:0]   hs [L];
    string        ht [L];

    bpa_adder #(.WIDTH(W)) u_dut (
        .clk_i(clk), .rst_i(rst), .in_valid_i(vin), .a_i(a), .b_i(b),
        .cin_i(cin), .out_valid_o(vout), .sum_o(sum), .cout_o(cout));

    always #4 clk = ~clk;

    task automatic clear_hist();
        for (int i = 0; i < L; i++) begin
            hv[i] = 1'b0;
            hs[i] = '0;
            ht[i] = "R1";
        end
    endtask

    task automatic check_reset_state(input string tag);
        checks++;
        if (vout !== 1'b0 || sum !== '0 || cout !== 1'b0) begin
            errors++;
            $display("FAIL %s: reset outputs v=%b s=%h c=%b expected v=0 s=0 c=0",
                     tag, vout, sum, cout);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic ci, input string vtag, input string dtag);
        checks++;
        if (vout !== hv[L-1]) begin
            errors++;
            $display("FAIL %s: out_valid actual %b expected %b", vtag, vout, hv[L-1]);
        end
        if (hv[L-1]) begin
            checks++;
            if ({cout, sum} !== hs[L-1]) begin
                errors++;
                $display("FAIL %s: result actual %h expected %h", ht[L-1], {cout, sum}, hs[L-1]);
            end
        end
        for (int i = L - 1; i > 0; i--) begin
            hv[i] = hv[i-1];
            hs[i] = hs[i-1];
            ht[i] = ht[i-1];
        end
        hv[0] = v;
        hs[0] = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        ht[0] = dtag;
        vin = v;
        a   = x;
        b   = y;
        cin = ci;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        clear_hist();
        vin = 1'b1;
        a = 4'hF;
        b = 4'hF;
        cin = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("R5");
        vin = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R1 R3: exhaustive back-to-back sweep
        for (int ci = 0; ci < 2; ci++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    step(1'b1, 4'(x), 4'(y), 1'(ci), "R3", "R1");

        // R7: bubbles inserted every third slot
        for (int n = 0; n < 512; n++) begin
            if (n % 3 == 2)
                step(1'b0, 4'(n * 7), 4'(n * 5), 1'(n), "R7", "R7");
            else
                step(1'b1, 4'(n), 4'(n >> 4), 1'(n >> 8), "R7", "R7");
        end

        // R4: full-length carry ripples
        step(1'b1, 4'hF, 4'h0, 1'b1, "R2", "R4");
        step(1'b1, 4'hF, 4'hF, 1'b1, "R2", "R4");
        step(1'b1, 4'h0, 4'h0, 1'b0, "R2", "R4");
        step(1'b1, 4'h8, 4'h8, 1'b0, "R2", "R4");
        step(1'b1, 4'h7, 4'h8, 1'b1, "R2", "R4");
        for (int i = 0; i < L + 1; i++) step(1'b0, 4'h0, 4'h0, 1'b0, "R2", "R2");

        // R6: reset with operations in flight
        step(1'b1, 4'hF, 4'hF, 1'b1, "R6", "R6");
        step(1'b1, 4'hA, 4'h5, 1'b0, "R6", "R6");
        step(1'b1, 4'h3, 4'hC, 1'b1, "R6", "R6");
        rst = 1'b1;
        vin = 1'b0;
        @(negedge clk);
        check_reset_state("R5");
        @(negedge clk);
        check_reset_state("R6");
        rst = 1'b0;
        clear_hist();
        @(negedge clk);
        for (int i = 0; i < L + 2; i++) step(1'b0, 4'h0, 4'h0, 1'b0, "R6", "R6");
        step(1'b1, 4'h9, 4'h9, 1'b0, "R2", "R1");
        for (int i = 0; i < L + 1; i++) step(1'b0, 4'h0, 4'h0, 1'b0, "R2", "R2");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule